// File: doc/BRIEF.md
# ALU Status Flag Generator

This unit forms the negative (N), carry (C) and overflow (V) status flags of a 16-bit processor ALU for every class of operation, in word or byte width. The datapath computes the result, and this unit takes that result along with the operands and the datapath's side signals. Those side signals are the carry out of the most significant bit of the selected width, the last bit shifted out, the shift count, a sticky OR of the bits discarded by a right shift, a multiply/divide range overflow, and the two bits of a Boolean bit operation. From these it derives the next flag values.

The three flags are held in a status register. The register loads only when the flag-write strobe is high, so the control logic decides which instructions change the flags. On a subtraction the carry flag records a borrow. On a right shift the overflow flag becomes a sticky rounding indicator. On bit operations N and C carry the XOR and AND of the two bits.

Top module: `alu_flag_gen`

## Requirements
- R1: For every operation code except 10 and 11, N equals the result's top bit: `res_i[15]` in word mode (`byte_i`=0) and `res_i[7]` in byte mode (`byte_i`=1).
- R2: With op code 0 (add), C equals `carry_i` and V is 1 exactly when the signed sum of the operands falls outside the range of the selected width.
- R3: With op codes 1 (subtract), 2 (compare) and 3 (negate), C equals the inverse of `carry_i` (a borrow). For codes 1 and 2, V is 1 exactly when the signed difference `opa_i - opb_i` falls outside the selected range. For code 3, V is 1 exactly when `opa_i` is the most negative value of the selected width (8000h or 80h).
- R4: With op codes 4 (logical), 9 (prioritize) and the unused codes 12 to 15, C and V are both 0.
- R5: With op code 5 (multiply), C is 0 and V equals `md_ovf_i`.
- R6: With op code 6 (divide), C is 0 and V is 1 when `md_ovf_i` is 1 or when the divisor `opb_i` is zero over the selected width.
- R7: With op code 7 (shift/rotate left), C equals `shift_last_i` when `shift_cnt_i` is non-zero and 0 when it is zero. V is 0.
- R8: With op code 8 (shift/rotate right), C follows the rule of R7, and V equals `shift_sticky_i` when `shift_cnt_i` is non-zero and 0 when it is zero.
- R9: With op code 10 (one-operand bit operation), N equals `bit_a_i` and C and V are 0.
- R10: With op code 11 (two-operand bit operation), N equals `bit_a_i` XOR `bit_b_i`, C equals their AND, and V is 0.
- R11: The flag outputs are 0 after reset. They take the new values on the clock edge where `wr_i` is 1 and otherwise keep their values.
- R12: In byte mode, bits 15:8 of `opa_i`, `opb_i` and `res_i` have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation class code |
| byte_i | input | 1 | 1 selects byte width, 0 selects word width |
| opa_i | input | 16 | First operand (minuend, or the operand to negate) |
| opb_i | input | 16 | Second operand (subtrahend or divisor) |
| res_i | input | 16 | Raw ALU result |
| carry_i | input | 1 | Adder carry out of the selected width's top bit |
| shift_last_i | input | 1 | Last bit shifted out |
| shift_cnt_i | input | 5 | Shift count |
| shift_sticky_i | input | 1 | OR of the bits discarded by a right shift before the last one |
| md_ovf_i | input | 1 | Multiply/divide result does not fit in a word |
| bit_a_i | input | 1 | First bit of a Boolean bit operation |
| bit_b_i | input | 1 | Second bit of a Boolean bit operation |
| wr_i | input | 1 | Flag-write strobe |
| n_o | output | 1 | Registered N flag |
| c_o | output | 1 | Registered C flag |
| v_o | output | 1 | Registered V flag |

## Verification
The bench builds the unit with its defaults: a 16-bit word, an 8-bit byte and a 5-bit shift count. With these values both sign-bit positions are exercised, along with the byte-mode masking of the upper half and the full 0 to 31 count range, including the zero-count case. Operands are chosen so that overflow, borrow and most-negative boundaries are hit in both widths. The bench supplies operands with random upper bytes in byte mode, which shows that the masking holds.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_CMP   = 4'd2,
    OP_NEG   = 4'd3,
    OP_LOGIC = 4'd4,
    OP_MUL   = 4'd5,
    OP_DIV   = 4'd6,
    OP_SHL   = 4'd7,
    OP_SHR   = 4'd8,
    OP_PRIO  = 4'd9,
    OP_BIT1  = 4'd10,
    OP_BIT2  = 4'd11
  } op_e;

  typedef struct packed {
    logic n;
    logic c;
    logic v;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/flag_sign.sv
`timescale 1ns/1ps
// Width-dependent sign and range tests for the selected data size.
module flag_sign #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  output logic              sign_res,
  output logic              ovf_add,
  output logic              ovf_sub,
  output logic              ovf_neg,
  output logic              zero_b
);

  localparam int WTOP = DATA_W - 1;
  localparam int BTOP = BYTE_W - 1;

  // the top bit, value is the most negative number of its width
  function automatic logic is_min_neg(input logic top, input logic [DATA_W-1:0] rest, input int unsigned w);
    logic below;
    below = 1'b0;
    for (int i = 0; i < DATA_W - 1; i++) begin
      if (i < int'(w) - 1) below = below | rest[i];
    end
    return top & ~below;
  endfunction

  function automatic logic add_range(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic sub_range(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  logic sign_a, sign_b;
  logic mneg_a;
  logic unused_res;

  generate
    if (BYTE_W < DATA_W) begin : g_two_sizes
      assign sign_a   = byte_sel ? opa[BTOP] : opa[WTOP];
      assign sign_b   = byte_sel ? opb[BTOP] : opb[WTOP];
      assign sign_res = byte_sel ? res[BTOP] : res[WTOP];
      assign zero_b   = byte_sel ? (opb[BTOP:0] == '0) : (opb == '0);
      assign mneg_a   = byte_sel ? is_min_neg(opa[BTOP], opa, BYTE_W)
                                 : is_min_neg(opa[WTOP], opa, DATA_W);
      assign unused_res = ^{res[WTOP-1:BTOP+1], res[BTOP-1:0]};
    end else begin : g_word_only
      assign sign_a   = opa[WTOP];
      assign sign_b   = opb[WTOP];
      assign sign_res = res[WTOP];
      assign zero_b   = (opb == '0);
      assign mneg_a   = is_min_neg(opa[WTOP], opa, DATA_W);
      assign unused_res = ^{byte_sel, res[WTOP-1:0]};
    end
  endgenerate

  assign ovf_add = add_range(sign_a, sign_b, sign_res);
  assign ovf_sub = sub_range(sign_a, sign_b, sign_res);
  assign ovf_neg = mneg_a;

endmodule

// File: rtl/flag_select.sv
`timescale 1ns/1ps
// Per-class choice of the next N, C and V values.
module flag_select
  import alu_flag_pkg::*;
(
  input  op_e    op,
  input  logic   sign_res,
  input  logic   ovf_add,
  input  logic   ovf_sub,
  input  logic   ovf_neg,
  input  logic   zero_b,
  input  logic   carry,
  input  logic   shift_last,
  input  logic   cnt_zero,
  input  logic   sticky,
  input  logic   md_ovf,
  input  logic   bit_a,
  input  logic   bit_b,
  output flags_t nxt
);

  logic shift_c;
  assign shift_c = shift_last & ~cnt_zero;

  always_comb begin
    nxt.n = sign_res;
    nxt.c = 1'b0;
    nxt.v = 1'b0;
    unique case (op)
      OP_ADD: begin
        nxt.c = carry;
        nxt.v = ovf_add;
      end
      OP_SUB, OP_CMP: begin
        nxt.c = ~carry;
        nxt.v = ovf_sub;
      end
      OP_NEG: begin
        nxt.c = ~carry;
        nxt.v = ovf_neg;
      end
      OP_MUL:  nxt.v = md_ovf;
      OP_DIV:  nxt.v = md_ovf | zero_b;
      OP_SHL:  nxt.c = shift_c;
      OP_SHR: begin
        nxt.c = shift_c;
        nxt.v = sticky & ~cnt_zero;
      end
      OP_BIT1: nxt.n = bit_a;
      OP_BIT2: begin
        nxt.n = bit_a ^ bit_b;
        nxt.c = bit_a & bit_b;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flag_store.sv
`timescale 1ns/1ps
// Strobed status register, cleared by reset.
module flag_store #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end

endmodule

// File: rtl/alu_flag_gen.sv
`timescale 1ns/1ps
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              shift_last_i,
  input  logic [CNT_W-1:0]  shift_cnt_i,
  input  logic              shift_sticky_i,
  input  logic              md_ovf_i,
  input  logic              bit_a_i,
  input  logic              bit_b_i,
  input  logic              wr_i,
  output logic              n_o,
  output logic              c_o,
  output logic              v_o
);

  // named internal events
  op_e    op_q;
  logic   sign_res;
  logic   ovf_add, ovf_sub, ovf_neg;
  logic   divisor_zero;
  logic   cnt_zero;
  flags_t nxt_flags;
  flags_t cur_flags;

  assign op_q     = op_e'(op_i);
  assign cnt_zero = (shift_cnt_i == '0);

  flag_sign #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_sign (
    .byte_sel (byte_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .res      (res_i),
    .sign_res (sign_res),
    .ovf_add  (ovf_add),
    .ovf_sub  (ovf_sub),
    .ovf_neg  (ovf_neg),
    .zero_b   (divisor_zero)
  );

  flag_select u_sel (
    .op         (op_q),
    .sign_res   (sign_res),
    .ovf_add    (ovf_add),
    .ovf_sub    (ovf_sub),
    .ovf_neg    (ovf_neg),
    .zero_b     (divisor_zero),
    .carry      (carry_i),
    .shift_last (shift_last_i),
    .cnt_zero   (cnt_zero),
    .sticky     (shift_sticky_i),
    .md_ovf     (md_ovf_i),
    .bit_a      (bit_a_i),
    .bit_b      (bit_b_i),
    .nxt        (nxt_flags)
  );

  flag_store #(.WIDTH(FLAG_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_i),
    .d     (nxt_flags),
    .q     (cur_flags)
  );

  assign n_o = cur_flags.n;
  assign c_o = cur_flags.c;
  assign v_o = cur_flags.v;

endmodule

// File: rtl/alu_flag_chk.sv
`timescale 1ns/1ps
module alu_flag_chk
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_i,
  input logic              byte_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              carry_i,
  input logic [CNT_W-1:0]  shift_cnt_i,
  input logic              bit_a_i,
  input logic              bit_b_i,
  input logic              wr_i,
  input logic              n_o,
  input logic              c_o,
  input logic              v_o
);

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_ADD) |=> (c_o == $past(carry_i)));

  p_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (op_i == OP_SUB || op_i == OP_CMP || op_i == OP_NEG)) |=> (c_o != $past(carry_i)));

  p_logic_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_LOGIC) |=> (!c_o && !v_o));

  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_DIV && (byte_i ? (opb_i[BYTE_W-1:0] == '0) : (opb_i == '0))) |=> v_o);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (op_i == OP_SHL || op_i == OP_SHR) && shift_cnt_i == '0) |=> (!c_o && !v_o));

  p_bit_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_BIT2) |=>
      (n_o == $past(bit_a_i ^ bit_b_i) && c_o == $past(bit_a_i & bit_b_i) && !v_o));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable({n_o, c_o, v_o}));

endmodule

bind alu_flag_gen alu_flag_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_i        (op_i),
  .byte_i      (byte_i),
  .opb_i       (opb_i),
  .carry_i     (carry_i),
  .shift_cnt_i (shift_cnt_i),
  .bit_a_i     (bit_a_i),
  .bit_b_i     (bit_b_i),
  .wr_i        (wr_i),
  .n_o         (n_o),
  .c_o         (c_o),
  .v_o         (v_o)
);

// File: tb/sim_alu_flag_gen.sv
`timescale 1ns/1ps
module sim_alu_flag_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] opa_i = '0, opb_i = '0, res_i = '0;
  logic        carry_i = 1'b0, shift_last_i = 1'b0, shift_sticky_i = 1'b0;
  logic [4:0]  shift_cnt_i = '0;
  logic        md_ovf_i = 1'b0, bit_a_i = 1'b0, bit_b_i = 1'b0, wr_i = 1'b0;
  logic        n_o, c_o, v_o;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_ncv = 3'b000;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_flag_gen u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i),
    .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i), .carry_i(carry_i),
    .shift_last_i(shift_last_i), .shift_cnt_i(shift_cnt_i),
    .shift_sticky_i(shift_sticky_i), .md_ovf_i(md_ovf_i),
    .bit_a_i(bit_a_i), .bit_b_i(bit_b_i), .wr_i(wr_i),
    .n_o(n_o), .c_o(c_o), .v_o(v_o)
  );

  function automatic int as_signed(input int x, input int w);
    return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
  endfunction

  function automatic bit out_of_range(input int s, input int w);
    return (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
  endfunction

  // behavioural reference for the flags the current inputs should produce
  function automatic logic [2:0] model();
    int w, mask, a, b, r, sa, sb;
    bit n, c, v;
    w = byte_i ? 8 : 16;
    mask = (1 << w) - 1;
    a = int'(opa_i) & mask;
    b = int'(opb_i) & mask;
    r = int'(res_i) & mask;
    sa = as_signed(a, w);
    sb = as_signed(b, w);
    n = ((r >> (w - 1)) & 1) == 1;
    c = 0;
    v = 0;
    case (int'(op_i))
      0: begin c = carry_i; v = out_of_range(sa + sb, w); end
      1, 2: begin c = !carry_i; v = out_of_range(sa - sb, w); end
      3: begin c = !carry_i; v = out_of_range(-sa, w); end
      5: v = md_ovf_i;
      6: v = md_ovf_i || (b == 0);
      7: c = (shift_cnt_i != 0) && shift_last_i;
      8: begin
        c = (shift_cnt_i != 0) && shift_last_i;
        v = (shift_cnt_i != 0) && shift_sticky_i;
      end
      10: n = bit_a_i;
      11: begin n = bit_a_i ^ bit_b_i; c = bit_a_i & bit_b_i; end
      default: ;
    endcase
    return {n, c, v};
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R2";
      1, 2, 3: return "R3";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      10: return "R9";
      11: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req);
    checks++;
    if ({n_o, c_o, v_o} !== exp_ncv) begin
      fails++;
      $display("FAIL %s: NCV actual %b expected %b (op %0d byte %0d)", req, {n_o, c_o, v_o}, exp_ncv, op_i, byte_i);
    end
  endtask

  task automatic tick(input string req);
    logic [2:0] nx;
    nx = model();
    @(posedge clk);
    if (rst_n && wr_i) exp_ncv = nx;
    #1;
    check(req);
  endtask

  task automatic drive(input int op, input bit byt, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] r, input bit cy, input bit last, input int cnt,
                       input bit st, input bit md, input bit ba, input bit bb, input bit w,
                       input string req);
    op_i = op[3:0]; byte_i = byt; opa_i = a; opb_i = b; res_i = r; carry_i = cy;
    shift_last_i = last; shift_cnt_i = cnt[4:0]; shift_sticky_i = st; md_ovf_i = md;
    bit_a_i = ba; bit_b_i = bb; wr_i = w;
    tick(req);
  endtask

  // forms a consistent result and carry for add/sub/cmp/neg
  task automatic arith(input int op, input bit byt, input logic [15:0] a, input logic [15:0] b,
                       input bit w, input string req);
    int wd, mask, am, bm, sum;
    logic [15:0] r;
    wd = byt ? 8 : 16;
    mask = (1 << wd) - 1;
    am = int'(a) & mask;
    bm = int'(b) & mask;
    case (op)
      0: sum = am + bm;
      3: sum = 0 + ((~am) & mask) + 1;
      default: sum = am + ((~bm) & mask) + 1;
    endcase
    r = 16'(sum & mask);
    if (byt) r[15:8] = 8'($urandom);
    drive(op, byt, a, b, r, ((sum >> wd) & 1) == 1, 0, 0, 0, 0, 0, 0, w, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11");                       // reset state
    rst_n = 1'b1;
    tick("R11");

    // R2 add
    arith(0, 0, 16'h7FFF, 16'h0001, 1, "R2");
    arith(0, 0, 16'hFFFF, 16'h0001, 1, "R2");
    arith(0, 0, 16'h8000, 16'h8000, 1, "R2");
    // R12 byte add with upper bytes set
    arith(0, 1, 16'h127F, 16'h3401, 1, "R12");
    arith(0, 1, 16'hFF10, 16'hFF20, 1, "R12");
    // R3 subtract, compare, negate
    arith(1, 0, 16'h8000, 16'h0001, 1, "R3");
    arith(1, 0, 16'h0000, 16'h0001, 1, "R3");
    arith(2, 1, 16'hAA80, 16'h5501, 1, "R3");
    arith(3, 0, 16'h8000, 16'h0000, 1, "R3");
    arith(3, 1, 16'h7780, 16'h0000, 1, "R3");
    arith(3, 0, 16'h0001, 16'h0000, 1, "R3");
    // R1 sign position
    drive(4, 1, 0, 0, 16'h0080, 1, 0, 0, 0, 0, 0, 0, 1, "R1");
    drive(4, 1, 0, 0, 16'h8000, 1, 0, 0, 0, 0, 0, 0, 1, "R1");
    drive(4, 0, 0, 0, 16'h8000, 1, 0, 0, 0, 1, 0, 0, 1, "R1");
    // R4 clears
    drive(9, 0, 0, 0, 16'h4000, 1, 1, 3, 1, 1, 0, 0, 1, "R4");
    drive(13, 0, 0, 0, 16'hFFFF, 1, 1, 3, 1, 1, 1, 1, 1, "R4");
    // R5 multiply, R6 divide
    drive(5, 0, 0, 16'h0003, 16'h1234, 1, 1, 0, 0, 1, 0, 0, 1, "R5");
    drive(6, 0, 0, 16'h0000, 16'h0000, 1, 0, 0, 0, 0, 0, 0, 1, "R6");
    drive(6, 0, 0, 16'h0100, 16'h0000, 1, 0, 0, 0, 0, 0, 0, 1, "R6");
    drive(6, 1, 0, 16'h1200, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 1, "R12");
    // R7 left shift
    drive(7, 0, 0, 0, 16'h0008, 0, 1, 3, 1, 0, 0, 0, 1, "R7");
    drive(7, 0, 0, 0, 16'h0008, 0, 1, 0, 1, 0, 0, 0, 1, "R7");
    // R8 right shift
    drive(8, 0, 0, 0, 16'h0001, 0, 1, 4, 1, 0, 0, 0, 1, "R8");
    drive(8, 0, 0, 0, 16'h0001, 0, 0, 4, 1, 0, 0, 0, 1, "R8");
    drive(8, 0, 0, 0, 16'h0001, 0, 1, 0, 1, 0, 0, 0, 1, "R8");
    // R9 and R10 bit operations
    drive(10, 0, 0, 0, 16'h0000, 1, 1, 1, 1, 1, 1, 0, 1, "R9");
    drive(11, 0, 0, 0, 16'h0000, 0, 0, 0, 0, 1, 1, 1, 1, "R10");
    drive(11, 0, 0, 0, 16'hFFFF, 0, 0, 0, 0, 1, 1, 0, 1, "R10");
    // R11 hold without strobe
    arith(0, 0, 16'h7FFF, 16'h7FFF, 1, "R2");
    drive(4, 0, 0, 0, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    drive(11, 0, 0, 0, 16'h0000, 0, 0, 0, 0, 0, 1, 1, 0, "R11");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      bit w;
      op = int'($urandom_range(0, 15));
      w = ($urandom_range(0, 3) != 0);
      if (op <= 3)
        arith(op, 1'($urandom), 16'($urandom), 16'($urandom), w, w ? req_of(op) : "R11");
      else
        drive(op, 1'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0) ? 16'h0000 : 16'($urandom),
              16'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 31)),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), w, w ? req_of(op) : "R11");
    end

    // reset in mid-run
    rst_n = 1'b0;
    exp_ncv = 3'b000;
    #1;
    check("R11");
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    wr_i = 1'b0;
    tick("R11");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule